// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit for a small 12-bit accumulator machine. It generates the machine's control strobes by stepping through microinstructions held in an internal control store. It does not compute them from a decoded opcode and a phase counter. The datapath gives it the 4-bit opcode from its instruction register and the sign bit of its accumulator. In return, the block drives sixteen register and ALU strobes and a halt line.

Each 24-bit microinstruction has two parts. The upper 16 bits are the strobes. The lower 8 bits form a sequencing field: a conditional bit, a dispatch bit, a halt bit and a 5-bit jump target.

A 5-bit micro-counter addresses the control store and advances on the rising clock edge. The microinstruction register loads the addressed word on the falling edge, so the strobes are stable across each rising edge of the datapath. A second small table maps each opcode to the first address of its routine. The whole microprogram is fixed inside the block.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `strobes` is 0 and `halt` is 0. After release, the first microinstruction presented is the first word of the fetch routine.
- R2: Strobe bit positions are: 0 pc_inc, 1 pc_out, 2 pc_load, 3 mar_load, 4 mem_rd, 5 mem_wr, 6 mdr_out, 7 mdr_load, 8 ir_out, 9 ir_load, 10 acc_out, 11 acc_load, 12 b_load, 13 alu_add, 14 alu_sub, 15 alu_out. The fetch routine is three consecutive cycles with these strobes: {pc_out, mar_load}, then {mem_rd}, then {mdr_out, ir_load, pc_inc}.
- R3: After the last fetch word, the routine is chosen by the opcode present at that moment. The mapping is: 0 starts fetch again, 1 load, 2 store, 3 add (start address 9), 4 subtract, 5 jump, 6 jump-if-negative, and 7 to 15 halt. Load starts at address 3.
- R4: The load routine is three cycles: {ir_out, mar_load}, {mem_rd}, {mdr_out, acc_load}. Fetch follows it.
- R5: The store routine is three cycles: {ir_out, mar_load}, {acc_out, mdr_load}, {mem_wr}. Fetch follows it.
- R6: The add routine is four cycles: {ir_out, mar_load}, {mem_rd}, {mdr_out, b_load}, {alu_add, alu_out, acc_load}. Subtract is the same with alu_sub in place of alu_add.
- R7: The unconditional jump routine is one cycle of {ir_out, pc_load}, followed by fetch.
- R8: In the jump-if-negative routine with `neg_flag` = 1, one idle cycle (all strobes 0) is followed by one cycle of {ir_out, pc_load}, and then fetch.
- R9: In the jump-if-negative routine with `neg_flag` = 0, two idle cycles follow, and then fetch. pc_load is never asserted.
- R10: `neg_flag` has no effect on any routine other than jump-if-negative.
- R11: When a halt opcode is dispatched, `halt` rises with all strobes 0 and stays that way whatever the inputs do, until `rst_n` is asserted.
- R12: Next-address rule: if the dispatch bit is set, the next address comes from the opcode table. Otherwise, if the conditional bit is set and `neg_flag` is 0, the next address is the current address plus one. In every other case it is the 5-bit jump target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; micro-counter on rising edge, microinstruction register on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Opcode field of the datapath instruction register |
| neg_flag | input | 1 | Sign bit of the accumulator |
| strobes | output | 16 | Control strobes to the datapath |
| halt | output | 1 | Machine halted |

## Verification
The bench runs the conditional branch both ways. If a design swapped the increment and jump choices, it would assert pc_load on a positive accumulator and miss it on a negative one. The bench also sets `neg_flag` high during a load routine, because a design that sampled the flag on every word would send that routine off its path. Opcode 0 is dispatched to check that it leads straight back into fetch. Halt is exercised at both ends of the halt opcode range while the inputs are changed. A sequencer that kept counting, or let the microinstruction register reload, would show non-zero strobes or a dropped halt.

// File: rtl/useq_ctrl.sv
module useq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  opcode,
  input  logic        neg_flag,
  output logic [15:0] strobes,
  output logic        halt
);
  localparam int AW = 5;
  localparam int SW = 16;
  localparam int WW = SW + 3 + AW;

  localparam logic [SW-1:0] PC_INC  = 16'h0001;
  localparam logic [SW-1:0] PC_OUT  = 16'h0002;
  localparam logic [SW-1:0] PC_LD   = 16'h0004;
  localparam logic [SW-1:0] MAR_LD  = 16'h0008;
  localparam logic [SW-1:0] MEM_RD  = 16'h0010;
  localparam logic [SW-1:0] MEM_WR  = 16'h0020;
  localparam logic [SW-1:0] MDR_OUT = 16'h0040;
  localparam logic [SW-1:0] MDR_LD  = 16'h0080;
  localparam logic [SW-1:0] IR_OUT  = 16'h0100;
  localparam logic [SW-1:0] IR_LD   = 16'h0200;
  localparam logic [SW-1:0] ACC_OUT = 16'h0400;
  localparam logic [SW-1:0] ACC_LD  = 16'h0800;
  localparam logic [SW-1:0] B_LD    = 16'h1000;
  localparam logic [SW-1:0] ALU_ADD = 16'h2000;
  localparam logic [SW-1:0] ALU_SUB = 16'h4000;
  localparam logic [SW-1:0] ALU_OUT = 16'h8000;

  localparam logic [AW-1:0] A_FETCH = 5'h00;
  localparam logic [AW-1:0] A_LOAD  = 5'h03;
  localparam logic [AW-1:0] A_STORE = 5'h06;
  localparam logic [AW-1:0] A_ADD   = 5'h09;
  localparam logic [AW-1:0] A_JMP   = 5'h0D;
  localparam logic [AW-1:0] A_JNEG  = 5'h0F;
  localparam logic [AW-1:0] A_SUB   = 5'h12;
  localparam logic [AW-1:0] A_STOP  = 5'h16;

  function automatic logic [WW-1:0] uw(input logic [SW-1:0] s, input logic c,
                                       input logic m, input logic h,
                                       input logic [AW-1:0] j);
    return {s, c, m, h, j};
  endfunction

  function automatic logic [WW-1:0] crom(input logic [AW-1:0] a);
    case (a)
      5'h00: crom = uw(PC_OUT | MAR_LD,            1'b0, 1'b0, 1'b0, 5'h01);
      5'h01: crom = uw(MEM_RD,                     1'b0, 1'b0, 1'b0, 5'h02);
      5'h02: crom = uw(MDR_OUT | IR_LD | PC_INC,   1'b0, 1'b1, 1'b0, 5'h00);
      5'h03: crom = uw(IR_OUT | MAR_LD,            1'b0, 1'b0, 1'b0, 5'h04);
      5'h04: crom = uw(MEM_RD,                     1'b0, 1'b0, 1'b0, 5'h05);
      5'h05: crom = uw(MDR_OUT | ACC_LD,           1'b0, 1'b0, 1'b0, A_FETCH);
      5'h06: crom = uw(IR_OUT | MAR_LD,            1'b0, 1'b0, 1'b0, 5'h07);
      5'h07: crom = uw(ACC_OUT | MDR_LD,           1'b0, 1'b0, 1'b0, 5'h08);
      5'h08: crom = uw(MEM_WR,                     1'b0, 1'b0, 1'b0, A_FETCH);
      5'h09: crom = uw(IR_OUT | MAR_LD,            1'b0, 1'b0, 1'b0, 5'h0A);
      5'h0A: crom = uw(MEM_RD,                     1'b0, 1'b0, 1'b0, 5'h0B);
      5'h0B: crom = uw(MDR_OUT | B_LD,             1'b0, 1'b0, 1'b0, 5'h0C);
      5'h0C: crom = uw(ALU_ADD | ALU_OUT | ACC_LD, 1'b0, 1'b0, 1'b0, A_FETCH);
      5'h0D: crom = uw(IR_OUT | PC_LD,             1'b0, 1'b0, 1'b0, A_FETCH);
      5'h0F: crom = uw('0,                         1'b1, 1'b0, 1'b0, 5'h11);
      5'h10: crom = uw('0,                         1'b0, 1'b0, 1'b0, A_FETCH);
      5'h11: crom = uw(IR_OUT | PC_LD,             1'b0, 1'b0, 1'b0, A_FETCH);
      5'h12: crom = uw(IR_OUT | MAR_LD,            1'b0, 1'b0, 1'b0, 5'h13);
      5'h13: crom = uw(MEM_RD,                     1'b0, 1'b0, 1'b0, 5'h14);
      5'h14: crom = uw(MDR_OUT | B_LD,             1'b0, 1'b0, 1'b0, 5'h15);
      5'h15: crom = uw(ALU_SUB | ALU_OUT | ACC_LD, 1'b0, 1'b0, 1'b0, A_FETCH);
      5'h16: crom = uw('0,                         1'b0, 1'b0, 1'b1, A_STOP);
      default: crom = '0;
    endcase
  endfunction

  function automatic logic [AW-1:0] arom(input logic [3:0] op);
    case (op)
      4'd0:    arom = A_FETCH;
      4'd1:    arom = A_LOAD;
      4'd2:    arom = A_STORE;
      4'd3:    arom = A_ADD;
      4'd4:    arom = A_SUB;
      4'd5:    arom = A_JMP;
      4'd6:    arom = A_JNEG;
      default: arom = A_STOP;
    endcase
  endfunction

  logic [AW-1:0] upc, upc_nxt;
  logic [WW-1:0] uir;

  wire          f_cd  = uir[AW+2];
  wire          f_map = uir[AW+1];
  wire [AW-1:0] f_jmp = uir[AW-1:0];

  assign halt    = uir[AW];
  assign strobes = uir[WW-1 -: SW];

  always_comb begin
    if (f_map)                  upc_nxt = arom(opcode);
    else if (f_cd && !neg_flag) upc_nxt = upc + 5'd1;
    else                        upc_nxt = f_jmp;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     upc <= '0;
    else if (!halt) upc <= upc_nxt;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n)     uir <= '0;
    else if (!halt) uir <= crom(upc);
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  opcode,
  input logic        neg_flag,
  input logic [4:0]  upc,
  input logic [23:0] uir,
  input logic        halt
);
  AST_DIRECT_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (!uir[7] && !uir[6] && !halt) |=> upc == $past(uir[4:0])); // R12

  AST_NEG_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (uir[7] && !uir[6] && !halt && neg_flag) |=> upc == $past(uir[4:0])); // R8

  AST_NEG_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (uir[7] && !uir[6] && !halt && !neg_flag) |=> upc == $past(upc) + 5'd1); // R9

  AST_DISPATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (uir[6] && !halt && opcode == 4'd1) |=> upc == 5'd3); // R3

  AST_DISPATCH_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (uir[6] && !halt && opcode == 4'd3) |=> upc == 5'd9); // R3

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt && $stable(upc) && $stable(uir)); // R11
endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .neg_flag(neg_flag),
  .upc(upc), .uir(uir), .halt(halt)
);

// File: tb/tb_useq_ctrl.sv
module tb_useq_ctrl;
  localparam int CLK_P = 10;

  localparam logic [15:0] PC_INC  = 16'h0001, PC_OUT  = 16'h0002, PC_LD   = 16'h0004;
  localparam logic [15:0] MAR_LD  = 16'h0008, MEM_RD  = 16'h0010, MEM_WR  = 16'h0020;
  localparam logic [15:0] MDR_OUT = 16'h0040, MDR_LD  = 16'h0080, IR_OUT  = 16'h0100;
  localparam logic [15:0] IR_LD   = 16'h0200, ACC_OUT = 16'h0400, ACC_LD  = 16'h0800;
  localparam logic [15:0] B_LD    = 16'h1000, ALU_ADD = 16'h2000, ALU_SUB = 16'h4000;
  localparam logic [15:0] ALU_OUT = 16'h8000;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] opcode;
  logic neg_flag;
  logic [15:0] strobes;
  logic halt;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  useq_ctrl dut (.clk(clk), .rst_n(rst_n), .opcode(opcode), .neg_flag(neg_flag),
                 .strobes(strobes), .halt(halt));

  task automatic chk(input logic [15:0] es, input logic eh, input string tag);
    checks++;
    if (strobes !== es || halt !== eh) begin
      errors++;
      $display("FAIL %s: strobes=%h halt=%b expected strobes=%h halt=%b",
               tag, strobes, halt, es, eh);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #(CLK_P*3/10);
  endtask

  task automatic word(input logic [15:0] es, input logic eh, input string tag);
    step();
    chk(es, eh, tag);
  endtask

  task automatic do_fetch(input logic [3:0] op);
    opcode = op;
    word(PC_OUT | MAR_LD, 1'b0, "R2 fetch0");
    word(MEM_RD, 1'b0, "R2 fetch1");
    word(MDR_OUT | IR_LD | PC_INC, 1'b0, "R2 fetch2");
  endtask

  task automatic t_reset;
    rst_n = 1'b0; opcode = 4'd0; neg_flag = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_P*3/10);
    chk(16'h0000, 1'b0, "R1 reset");
    rst_n = 1'b1;
  endtask

  task automatic t_load(input logic nf);
    neg_flag = nf;
    do_fetch(4'd1);
    word(IR_OUT | MAR_LD, 1'b0, "R4 R10 load0");
    word(MEM_RD, 1'b0, "R4 R10 load1");
    word(MDR_OUT | ACC_LD, 1'b0, "R4 R10 load2");
  endtask

  task automatic t_store;
    do_fetch(4'd2);
    word(IR_OUT | MAR_LD, 1'b0, "R5 store0");
    word(ACC_OUT | MDR_LD, 1'b0, "R5 store1");
    word(MEM_WR, 1'b0, "R5 store2");
  endtask

  task automatic t_arith(input logic sub);
    do_fetch(sub ? 4'd4 : 4'd3);
    word(IR_OUT | MAR_LD, 1'b0, "R6 arith0");
    word(MEM_RD, 1'b0, "R6 arith1");
    word(MDR_OUT | B_LD, 1'b0, "R6 arith2");
    word((sub ? ALU_SUB : ALU_ADD) | ALU_OUT | ACC_LD, 1'b0, "R6 arith3");
  endtask

  task automatic t_jump;
    do_fetch(4'd5);
    word(IR_OUT | PC_LD, 1'b0, "R7 jump");
  endtask

  task automatic t_jneg(input logic nf);
    neg_flag = nf;
    do_fetch(4'd6);
    word(16'h0000, 1'b0, "R8 R9 jn test");
    if (nf) word(IR_OUT | PC_LD, 1'b0, "R8 jn taken");
    else    word(16'h0000, 1'b0, "R9 jn not taken");
    neg_flag = 1'b0;
  endtask

  task automatic t_map_zero;
    do_fetch(4'd0);
  endtask

  task automatic t_halt(input logic [3:0] op);
    do_fetch(op);
    word(16'h0000, 1'b1, "R11 halt entry");
    for (int i = 0; i < 5; i++) begin
      opcode = 4'(i + 1);
      neg_flag = i[0];
      word(16'h0000, 1'b1, "R11 halt hold");
    end
    rst_n = 1'b0;
    #1;
    chk(16'h0000, 1'b0, "R1 R11 reset from halt");
    step();
    rst_n = 1'b1;
    neg_flag = 1'b0;
  endtask

  initial begin
    #(CLK_P*100000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_load(1'b0);
    t_load(1'b1);
    t_store();
    t_arith(1'b0);
    t_arith(1'b1);
    t_jump();
    t_jneg(1'b1);
    t_jneg(1'b0);
    t_map_zero();
    t_load(1'b0);
    t_halt(4'd7);
    t_load(1'b1);
    t_halt(4'd15);
    t_store();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule